// File: doc/BRIEF.md
# Fractional-Period Compare Tick Generator

This block emits a one-cycle tick at a rate that is a fixed multiple of a slower reference whose period is measured elsewhere. It watches a free-running 16-bit counter shared with other logic and fires when the counter reaches a compare point. The compare point is the integer part of a 32-bit accumulator in 16.16 fixed point. The accumulator advances by a programmable period at every tick. Each compare is a whole cycle, but the average spacing between ticks keeps the fractional part of the period.

The period can be retuned at run time. A measurement of the reference period, in clock cycles, arrives with a strobe. The block scales it by the constant ratio between tick rate and reference rate and loads the result into its period register in a single cycle. Repeated retuning from fresh measurements makes the block behave as a frequency-lock loop. After reset it runs at the nominal period that the clock, tick and reference rate parameters define.

Top module: `frac_tick_gen`

## Requirements
- R1: During reset and in the cycle after it, tick is 0. After reset the period is round(CLK_HZ/TICK_HZ)·65536 and the accumulator sits at that value. So the first tick comes in the cycle after the counter input equals the upper 16 bits of that value: a counter value of 40 for a 40-cycle nominal period.
- R2: Tick is high for exactly one cycle. It rises in the cycle after the one in which the counter input equals the compare value, which is the accumulator's upper 16 bits.
- R3: In every cycle where the counter matches, the period is added to the accumulator. So the average tick spacing equals period/65536 cycles with fractional precision. A period of 0x002A8000 (42.5 cycles) gives four successive intervals that sum to exactly 170 cycles.
- R4: A measured reference period m, taken while the strobe is high, loads period = round(m·65536/RATIO), where RATIO = TICK_HZ/REF_HZ. With RATIO 40: 1600→2621440, 1601→2623078, 1599→2619802, 1603→2626355, 1587→2600141, 1700→2785280.
- R5: A new period first takes effect at the next accumulator addition. It never moves a compare value that is already pending.
- R6: If the strobe and a counter match fall in the same cycle, that cycle's addition uses the old period. The new period applies from the following tick.
- R7: The accumulator wraps modulo 2^32 together with the 16-bit counter, so ticks keep their spacing across counter rollover.
- R8: While the strobe is low, the period does not change, whatever the value on the measurement input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cntIn | input | CNT_W (16) | Shared free-running counter value |
| measPeriod | input | MEAS_W (24) | Measured reference period in clock cycles |
| measValid | input | 1 | One-cycle strobe: scale and load measPeriod |
| tick | output | 1 | One-cycle tick pulse |

## Verification
Four properties are checked in every cycle. A tick never lasts two cycles. The period register holds its value while the strobe is low. The compare value stays fixed between matches. Each advance moves the compare value by the integer part of the period or by one more.

The exact cycle of every tick, the rounding of the scaled period, when a retune takes effect (including a strobe in a match cycle), and behaviour across counter rollover all depend on arithmetic over many cycles. Only the bench's scenarios can show them: it runs a cycle-accurate 16.16 model fed with hand-computed period words.

// File: rtl/frac_tick_pkg.sv
package frac_tick_pkg;

  // Strobes from control to datapath.
  typedef struct packed {
    logic advance;     // counter matched: add period to accumulator
    logic loadPeriod;  // load scaled measurement into period register
  } tickCtrl_t;

  // Whole cycles per tick, rounded, moved into the 16.16 integer field.
  function automatic logic [31:0] nominalPeriod(input int unsigned clkHz,
                                                input int unsigned tickHz);
    logic [31:0] whole;
    whole = 32'((clkHz + tickHz / 2) / tickHz);
    return whole << 16;
  endfunction

endpackage

// File: rtl/frac_tick_ctrl.sv
module frac_tick_ctrl
  import frac_tick_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] cntIn,
  input  logic [CNT_W-1:0] cmpVal,
  input  logic             measValid,
  output tickCtrl_t        ctrl,
  output logic             tick
);

  logic matchNow;

  always_comb begin
    matchNow        = (cntIn == cmpVal);
    ctrl.advance    = matchNow;
    ctrl.loadPeriod = measValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) tick <= 1'b0;
    else       tick <= matchNow;
  end

  // R2: a tick never lasts longer than one cycle
  a_r2_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    tick |=> !tick);

endmodule

// File: rtl/frac_tick_dp.sv
module frac_tick_dp
  import frac_tick_pkg::*;
#(
  parameter int          CNT_W      = 16,
  parameter int          FRAC_W     = 16,
  parameter int          MEAS_W     = 24,
  parameter int unsigned RATIO      = 40,
  parameter logic [31:0] NOM_PERIOD = 32'd436928512
) (
  input  logic              clk,
  input  logic              rstN,
  input  tickCtrl_t         ctrl,
  input  logic [MEAS_W-1:0] measPeriod,
  output logic [CNT_W-1:0]  cmpVal
);

  localparam int ACC_W  = CNT_W + FRAC_W;
  localparam int PROD_W = MEAS_W + FRAC_W + 1;
  localparam logic [PROD_W-1:0] DIVISOR = PROD_W'(RATIO);
  localparam logic [PROD_W-1:0] HALF    = PROD_W'(RATIO / 2);
  localparam logic [ACC_W-1:0]  NOM_ACC = ACC_W'(NOM_PERIOD);

  logic [ACC_W-1:0]  periodReg;
  logic [ACC_W-1:0]  accReg;
  logic [ACC_W-1:0]  scaled;
  logic [PROD_W-1:0] numer;
  logic [PROD_W-1:0] quot;

  // Scale measured cycles by 2^FRAC_W / RATIO, round to nearest.
  always_comb begin
    numer = {1'b0, measPeriod, {FRAC_W{1'b0}}} + HALF;
    quot  = numer / DIVISOR;
  end

  generate
    if (PROD_W > ACC_W) begin : g_sat
      always_comb scaled = (|quot[PROD_W-1:ACC_W]) ? '1 : quot[ACC_W-1:0];
    end else begin : g_fit
      always_comb scaled = ACC_W'(quot);
    end
  endgenerate

  // Single-register period: a whole word is swapped in one edge.
  always_ff @(posedge clk) begin
    if (!rstN)                periodReg <= NOM_ACC;
    else if (ctrl.loadPeriod) periodReg <= scaled;
  end

  // Accumulator holds the pending compare point (origin 0 plus one period).
  always_ff @(posedge clk) begin
    if (!rstN)             accReg <= NOM_ACC;
    else if (ctrl.advance) accReg <= accReg + periodReg;
  end

  assign cmpVal = accReg[ACC_W-1:FRAC_W];

  // R8: period only changes on a strobe
  a_r8_period_hold: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.loadPeriod |=> $stable(periodReg));

  // R5: a pending compare is never moved between matches
  a_r5_cmp_hold: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.advance |=> $stable(cmpVal));

  // R3: each advance steps the compare by the whole part of the period, or one more
  a_r3_cmp_step: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.advance |=> (CNT_W'(cmpVal - $past(cmpVal)
                      - $past(periodReg[ACC_W-1:FRAC_W])) <= CNT_W'(1)));

endmodule

// File: rtl/frac_tick_gen.sv
module frac_tick_gen
  import frac_tick_pkg::*;
#(
  parameter int unsigned CLK_HZ  = 16_000_000,
  parameter int unsigned TICK_HZ = 2400,
  parameter int unsigned REF_HZ  = 60,
  parameter int          CNT_W   = 16,
  parameter int          MEAS_W  = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CNT_W-1:0]  cntIn,
  input  logic [MEAS_W-1:0] measPeriod,
  input  logic              measValid,
  output logic              tick
);

  localparam int          FRAC_W = 16;
  localparam int unsigned RATIO  = TICK_HZ / REF_HZ;
  localparam logic [31:0] NOM    = nominalPeriod(CLK_HZ, TICK_HZ);

  tickCtrl_t        ctrl;
  logic [CNT_W-1:0] cmpVal;

  frac_tick_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cntIn     (cntIn),
    .cmpVal    (cmpVal),
    .measValid (measValid),
    .ctrl      (ctrl),
    .tick      (tick)
  );

  frac_tick_dp #(
    .CNT_W      (CNT_W),
    .FRAC_W     (FRAC_W),
    .MEAS_W     (MEAS_W),
    .RATIO      (RATIO),
    .NOM_PERIOD (NOM)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrl),
    .measPeriod (measPeriod),
    .cmpVal     (cmpVal)
  );

endmodule

// File: tb/frac_tick_gen_tb.sv
module frac_tick_gen_tb;

  localparam logic [31:0] NOM = 32'h0028_0000; // 40 cycles

  typedef struct packed {
    logic [23:0] meas;
    logic [31:0] per;
  } vec_t;

  // R4: hand-computed round(m*65536/40)
  localparam vec_t VEC [6] = '{
    '{24'd1600, 32'd2621440},
    '{24'd1601, 32'd2623078},
    '{24'd1599, 32'd2619802},
    '{24'd1603, 32'd2626355},
    '{24'd1587, 32'd2600141},
    '{24'd1700, 32'd2785280}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] cnt;
  logic [23:0] measPeriod = 24'd1600;
  logic        measValid = 1'b0;
  logic        tick;

  logic [31:0] mPt, mPer, pendExp;
  logic        expTick;
  bit          started = 1'b0;
  int          cycle = 0;
  int          checks = 0;
  int          errors = 0;
  string       curTag = "R2";

  always #5 clk = ~clk;

  frac_tick_gen #(
    .CLK_HZ(96_000), .TICK_HZ(2400), .REF_HZ(60), .CNT_W(16), .MEAS_W(24)
  ) u_dut (
    .clk(clk), .rstN(rstN), .cntIn(cnt), .measPeriod(measPeriod),
    .measValid(measValid), .tick(tick)
  );

  // Counter source and 16.16 reference model of the tick schedule.
  always @(posedge clk) begin
    cycle <= cycle + 1;
    if (!rstN) begin
      cnt <= '0; mPt <= NOM; mPer <= NOM; expTick <= 1'b0;
    end else begin
      cnt     <= cnt + 16'd1;
      expTick <= (cnt == mPt[31:16]);
      if (cnt == mPt[31:16]) mPt <= mPt + mPer;
      if (measValid) mPer <= pendExp;
    end
  end

  task automatic check(input bit ok, input string tag,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycle);
    end
  endtask

  always @(negedge clk)
    if (started && rstN && (tick || expTick))
      check(tick == expTick, curTag, tick, expTick);

  task automatic applyMeas(input logic [23:0] m, input logic [31:0] p);
    @(negedge clk);
    measPeriod = m; pendExp = p; measValid = 1'b1;
    @(negedge clk);
    measValid = 1'b0;
  endtask

  task automatic waitTicks(input int n);
    for (int i = 0; i < n; i++) begin
      do @(negedge clk); while (!tick);
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog all-reqs actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    pendExp = NOM;
    // R1: quiet in reset
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(tick == 1'b0, "R1", tick, 0);
    end
    rstN = 1'b1;
    started = 1'b1;
    @(negedge clk);
    check(tick == 1'b0, "R1", tick, 0);
    // R1: first tick one cycle after counter reaches 40
    for (int i = 0; i < 200; i++) begin
      if (tick) break;
      @(negedge clk);
    end
    check(cnt == 16'd41, "R1", cnt, 41);
    curTag = "R2";
    waitTicks(4);

    // R4: table of measurements and scaled periods
    curTag = "R4";
    foreach (VEC[k]) begin
      applyMeas(VEC[k].meas, VEC[k].per);
      waitTicks(8);
    end

    // R3: 42.5-cycle period, four intervals sum to 170
    curTag = "R3";
    applyMeas(24'd1700, 32'd2785280);
    waitTicks(2);
    begin
      int t0;
      t0 = cycle;
      waitTicks(4);
      check(cycle - t0 == 170, "R3", cycle - t0, 170);
    end

    // R5: strobe between matches does not move the pending compare
    curTag = "R5";
    waitTicks(1);
    repeat (10) @(negedge clk);
    applyMeas(24'd1601, 32'd2623078);
    waitTicks(4);

    // R6: strobe in the same cycle as a match
    curTag = "R6";
    forever begin
      @(negedge clk);
      if (cnt == mPt[31:16]) break;
    end
    measPeriod = 24'd1605; pendExp = 32'd2629632; measValid = 1'b1;
    @(negedge clk);
    measValid = 1'b0;
    waitTicks(6);

    // R8: measurement changes without strobe are ignored
    curTag = "R8";
    measPeriod = 24'd1700;
    waitTicks(6);
    measPeriod = 24'd900;
    waitTicks(6);

    // R7: run through counter rollover
    curTag = "R7";
    repeat (70000) @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule